// File: doc/BRIEF.md
# Second-level cache control decoder

This block keeps the cache control byte of a host bridge and turns it, together with the cache-size setting and the processor cycle on the bus, into registered per-cycle controls for a second-level cache controller. It drives the processor's cache-enable qualifier (active low), a hit indication for normal operation, a forced-miss indication, a tag-invalidate strobe on reads, and the early next-address request (active low). In a two-bank arrangement of pipelined-burst SRAM, the next-address request is held back by one clock.

The two SRAM-type bits take their first value from two strap pins. These pins are sampled inverted on the first clock after reset is released. Software can overwrite the bits later through the write port. The first-level enable bit and the force-miss bit together choose one of four second-level behaviours. A cache-size value of zero means no second-level cache is fitted. In that case every second-level indication stays quiet.

Top module: `l2ctl_top`

## Requirements
- R1: While rst_ni is low, rd_data_o reads 0x00, ken_no and na_no are 1, and l2_hit_o, force_miss_o and tag_inval_o are 0.
- R2: On the first clock edge after rst_ni rises, bits 5:4 load the bitwise inverse of strap_i. A later write replaces them.
- R3: A write takes effect on the next clock edge. Bits 0, 1, 3, 5 and 4 read back as written. Bits 7, 6 and 2 always read 0.
- R4: ken_no is 0 in the cycle after a valid cacheable cycle when bit 0 is 1. Otherwise it is 1.
- R5: With size_i = 00, l2_hit_o, force_miss_o, tag_inval_o stay 0 and na_no stays 1, whatever bits 1:0 hold.
- R6: Bit 0 = 1 and bit 1 = 0 (normal): l2_hit_o is 1 in the cycle after a valid cycle with tag_hit_i = 1.
- R7: Bit 0 = 1 and bit 1 = 1 (forced miss): l2_hit_o stays 0, and force_miss_o is 1 after every valid cycle, read or write.
- R8: Bit 0 = 0 and bit 1 = 1 (invalidate): tag_inval_o is 1 after valid read cycles only, and l2_hit_o stays 0.
- R9: Bits 1:0 = 00: no hit, forced-miss or invalidate indication is given.
- R10: With bit 3 = 0 and SRAM type 00, or type 11 with size_i other than 10, na_no is 0 for one cycle, one cycle after a valid burst read that hits in normal mode.
- R11: With SRAM type 11 and size_i = 10, the same na_no pulse comes two cycles after the cycle instead of one.
- R12: With bit 3 = 1, or SRAM type 01 or 10, na_no stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 2 | Strap pins giving the inverted SRAM type at reset release |
| size_i | input | 2 | Cache-size field, 00 = no second-level cache |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte write data |
| rd_data_o | output | 8 | Current control byte contents |
| cyc_valid_i | input | 1 | A processor cycle is presented |
| cyc_read_i | input | 1 | Cycle is a read |
| cyc_burst_i | input | 1 | Cycle is a burst |
| cyc_cacheable_i | input | 1 | Cycle targets cacheable memory |
| tag_hit_i | input | 1 | Tag lookup matched |
| ken_no | output | 1 | Cache-enable qualifier, active low |
| l2_hit_o | output | 1 | Second-level hit in normal operation |
| force_miss_o | output | 1 | Lookup forced to miss |
| tag_inval_o | output | 1 | Invalidate selected tag entry |
| na_no | output | 1 | Next-address request, active low |

## Verification
Every per-cycle result except the next-address request is due one clock after the edge that takes the cycle. The normal next-address pulse is due at that same point. The held-back two-bank pulse is due one clock later. Register contents are due one clock after the write strobe, and the strap load is due one clock after reset release. The driver records each expectation with the exact cycle number at which it is due. It also leaves two idle cycles after each stimulus, so that no late pulse overlaps the next result. The monitor pops and compares each expectation only in that cycle, half a period after the edge.

// File: rtl/l2ctl_pkg.sv
package l2ctl_pkg;
  localparam int unsigned CTL_W   = 8;
  localparam int unsigned SIZE_W  = 2;
  localparam int unsigned STRAP_W = 2;
  localparam int unsigned L1_BIT  = 0;
  localparam int unsigned FM_BIT  = 1;
  localparam int unsigned NAD_BIT = 3;
  localparam int unsigned SRAM_LSB = 4;

  typedef enum logic [1:0] {
    SRAM_PB   = 2'b00,
    SRAM_RSV1 = 2'b01,
    SRAM_RSV2 = 2'b10,
    SRAM_PB2  = 2'b11
  } sram_kind_e;

  typedef enum logic [1:0] {
    L2_OFF    = 2'b00,
    L2_INVAL  = 2'b01,
    L2_NORMAL = 2'b10,
    L2_FORCE  = 2'b11
  } l2_mode_e;

  typedef enum logic [1:0] {
    NA_OFF  = 2'b00,
    NA_NEXT = 2'b01,
    NA_LATE = 2'b10
  } na_mode_e;

  typedef struct packed {
    sram_kind_e sram;
    logic       na_off;
    logic       force_mi;
    logic       l1_en;
  } ctl_t;

  typedef struct packed {
    logic valid;
    logic read;
    logic burst;
    logic cacheable;
    logic hit;
  } cyc_t;
endpackage

// File: rtl/l2ctl_reg.sv
module l2ctl_reg
  import l2ctl_pkg::*;
#(
  parameter int unsigned DATA_W = CTL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [STRAP_W-1:0]  strap_i,
  output ctl_t                ctl_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  ctl_t ctl_q, wr_fields;
  logic load_pend_q;
  logic unused_bits;

  assign unused_bits = ^{wr_data_i[DATA_W-1:SRAM_LSB+2], wr_data_i[2]};

  always_comb begin
    wr_fields.l1_en    = wr_data_i[L1_BIT];
    wr_fields.force_mi = wr_data_i[FM_BIT];
    wr_fields.na_off   = wr_data_i[NAD_BIT];
    wr_fields.sram     = sram_kind_e'(wr_data_i[SRAM_LSB +: 2]);
  end

  // strap load on first edge after reset release wins over a write to bits 5:4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q       <= '0;
      load_pend_q <= 1'b1;
    end else begin
      load_pend_q <= 1'b0;
      if (wr_en_i) ctl_q <= wr_fields;
      if (load_pend_q) ctl_q.sram <= sram_kind_e'(~strap_i);
    end
  end

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[L1_BIT]           = ctl_q.l1_en;
    rd_data_o[FM_BIT]           = ctl_q.force_mi;
    rd_data_o[NAD_BIT]          = ctl_q.na_off;
    rd_data_o[SRAM_LSB +: 2]    = ctl_q.sram;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/l2ctl_mode.sv
module l2ctl_mode
  import l2ctl_pkg::*;
#(
  parameter logic [SIZE_W-1:0] TWO_BANK_SIZE = 2'b10
) (
  input  ctl_t              ctl_i,
  input  logic [SIZE_W-1:0] size_i,
  output l2_mode_e          l2_mode_o,
  output na_mode_e          na_mode_o,
  output logic              populated_o
);
  assign populated_o = |size_i;

  always_comb begin
    unique case ({ctl_i.l1_en, ctl_i.force_mi})
      2'b10:   l2_mode_o = L2_NORMAL;
      2'b11:   l2_mode_o = L2_FORCE;
      2'b01:   l2_mode_o = L2_INVAL;
      default: l2_mode_o = L2_OFF;
    endcase
  end

  always_comb begin
    na_mode_o = NA_OFF;
    if (!ctl_i.na_off && populated_o) begin
      unique case (ctl_i.sram)
        SRAM_PB:  na_mode_o = NA_NEXT;
        SRAM_PB2: na_mode_o = (size_i == TWO_BANK_SIZE) ? NA_LATE : NA_NEXT;
        default:  na_mode_o = NA_OFF;
      endcase
    end
  end
endmodule

// File: rtl/l2ctl_cycle.sv
module l2ctl_cycle
  import l2ctl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cyc_t     cyc_i,
  input  l2_mode_e l2_mode_i,
  input  na_mode_e na_mode_i,
  input  logic     populated_i,
  output logic     ken_no,
  output logic     l2_hit_o,
  output logic     force_miss_o,
  output logic     tag_inval_o,
  output logic     na_no
);
  logic l1_on, ken_d, hit_d, fmiss_d, inval_d, na_req, na_now, late_q;

  assign l1_on   = (l2_mode_i == L2_NORMAL) || (l2_mode_i == L2_FORCE);
  assign ken_d   = cyc_i.valid && cyc_i.cacheable && l1_on;
  assign hit_d   = cyc_i.valid && populated_i && (l2_mode_i == L2_NORMAL) && cyc_i.hit;
  assign fmiss_d = cyc_i.valid && populated_i && (l2_mode_i == L2_FORCE);
  assign inval_d = cyc_i.valid && populated_i && (l2_mode_i == L2_INVAL) && cyc_i.read;
  // burst read served from the second-level cache
  assign na_req  = hit_d && cyc_i.read && cyc_i.burst;
  assign na_now  = na_req && (na_mode_i == NA_NEXT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ken_no       <= 1'b1;
      l2_hit_o     <= 1'b0;
      force_miss_o <= 1'b0;
      tag_inval_o  <= 1'b0;
      na_no        <= 1'b1;
      late_q       <= 1'b0;
    end else begin
      ken_no       <= !ken_d;
      l2_hit_o     <= hit_d;
      force_miss_o <= fmiss_d;
      tag_inval_o  <= inval_d;
      late_q       <= na_req && (na_mode_i == NA_LATE);
      na_no        <= !(na_now || late_q);
    end
  end
endmodule

// File: rtl/l2ctl_top.sv
module l2ctl_top
  import l2ctl_pkg::*;
#(
  parameter logic [SIZE_W-1:0] TWO_BANK_SIZE = 2'b10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic               wr_en_i,
  input  logic [CTL_W-1:0]   wr_data_i,
  output logic [CTL_W-1:0]   rd_data_o,
  input  logic               cyc_valid_i,
  input  logic               cyc_read_i,
  input  logic               cyc_burst_i,
  input  logic               cyc_cacheable_i,
  input  logic               tag_hit_i,
  output logic               ken_no,
  output logic               l2_hit_o,
  output logic               force_miss_o,
  output logic               tag_inval_o,
  output logic               na_no
);
  ctl_t     ctl;
  l2_mode_e l2_mode;
  na_mode_e na_mode;
  logic     populated;
  cyc_t     cyc;

  assign cyc = '{valid: cyc_valid_i, read: cyc_read_i, burst: cyc_burst_i,
                 cacheable: cyc_cacheable_i, hit: tag_hit_i};

  l2ctl_reg #(.DATA_W(CTL_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .strap_i   (strap_i),
    .ctl_o     (ctl),
    .rd_data_o (rd_data_o)
  );

  l2ctl_mode #(.TWO_BANK_SIZE(TWO_BANK_SIZE)) u_mode (
    .ctl_i       (ctl),
    .size_i      (size_i),
    .l2_mode_o   (l2_mode),
    .na_mode_o   (na_mode),
    .populated_o (populated)
  );

  l2ctl_cycle u_cycle (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_i        (cyc),
    .l2_mode_i    (l2_mode),
    .na_mode_i    (na_mode),
    .populated_i  (populated),
    .ken_no       (ken_no),
    .l2_hit_o     (l2_hit_o),
    .force_miss_o (force_miss_o),
    .tag_inval_o  (tag_inval_o),
    .na_no        (na_no)
  );
endmodule

// File: rtl/l2ctl_sva.sv
module l2ctl_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] size_i,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       cyc_valid_i,
  input logic       cyc_read_i,
  input logic       ken_no,
  input logic       l2_hit_o,
  input logic       force_miss_o,
  input logic       tag_inval_o,
  input logic       na_no
);
  assert_ken_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_data_o[0]) |-> ken_no);

  assert_na_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_data_o[3]) && $past(rd_data_o[3], 2)) |-> na_no);

  assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({l2_hit_o, force_miss_o, tag_inval_o}));

  assert_inval_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_inval_o |-> $past(cyc_valid_i && cyc_read_i));

  assert_nosize_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(size_i) == 2'b00) |-> !(l2_hit_o || force_miss_o || tag_inval_o));

  assert_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) |-> (rd_data_o[3:0] == ($past(wr_data_i[3:0]) & 4'b1011)));

  assert_rsv_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[7:6] == 2'b00) && !rd_data_o[2]);
endmodule

bind l2ctl_top l2ctl_sva u_sva (.*);

// File: tb/tb_l2ctl_top.sv
`timescale 1ns/1ps
module tb_l2ctl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap = 2'b00;
  logic [1:0] size = 2'b01;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       v = 0, rd = 0, bu = 0, ca = 0, th = 0;
  logic       ken_n, hit, fmiss, inval, na_n;

  int checks = 0, fails = 0, cyc = 0;

  logic       m_l1 = 0, m_fm = 0, m_nad = 0;
  logic [1:0] m_sram = 2'b00;

  typedef struct {int due; string req; logic [4:0] exp;} sb_item_t;
  sb_item_t sb_q[$];
  sb_item_t item;

  l2ctl_top dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .size_i(size),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .cyc_valid_i(v), .cyc_read_i(rd), .cyc_burst_i(bu),
    .cyc_cacheable_i(ca), .tag_hit_i(th),
    .ken_no(ken_n), .l2_hit_o(hit), .force_miss_o(fmiss),
    .tag_inval_o(inval), .na_no(na_n)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare each expectation in its due cycle
  always begin
    @(negedge clk);
    #1;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item = sb_q.pop_front();
      if (item.due < cyc) check(item.req, 8'hEE, {3'b0, item.exp});
      else check(item.req, {3'b0, ken_n, hit, fmiss, inval, na_n}, {3'b0, item.exp});
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_l1 = d[0]; m_fm = d[1]; m_nad = d[3]; m_sram = d[5:4];
  endtask

  // bits of exp: {ken_n, hit, fmiss, inval, na_n}
  task automatic drive(string req, logic iv, logic ird, logic ibu, logic ica, logic ith);
    logic pop, l1on, e_hit, e_fm, e_inv, e_ken, nareq, late;
    int c;
    @(negedge clk);
    v = iv; rd = ird; bu = ibu; ca = ica; th = ith;
    c = cyc;
    pop   = (size != 2'b00);
    l1on  = m_l1;
    e_ken = !(iv && ica && l1on);
    e_hit = iv && pop && l1on && !m_fm && ith;
    e_fm  = iv && pop && l1on && m_fm;
    e_inv = iv && pop && !l1on && m_fm && ird;
    nareq = e_hit && ird && ibu && !m_nad && (m_sram == 2'b00 || m_sram == 2'b11);
    late  = (m_sram == 2'b11) && (size == 2'b10);
    sb_q.push_back('{c + 1, req, {e_ken, e_hit, e_fm, e_inv, !(nareq && !late)}});
    sb_q.push_back('{c + 2, req, {1'b1, 1'b0, 1'b0, 1'b0, !(nareq && late)}});
    @(negedge clk);
    v = 0; rd = 0; bu = 0; ca = 0; th = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", rd_data, 8'h00);
    check("R1", {3'b0, ken_n, hit, fmiss, inval, na_n}, 8'h11);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", rd_data, 8'h30);  // strap 00 inverted -> type 11
    m_sram = 2'b11;
    strap = 2'b11;
    @(negedge clk);
    check("R2", rd_data, 8'h30);  // strap no longer sampled

    wr(8'hFF); check("R3", rd_data, 8'h3B);
    wr(8'h00); check("R3", rd_data, 8'h00);
    wr(8'h20); check("R2", rd_data, 8'h20);

    size = 2'b01;
    wr(8'h01);
    drive("R4 R6 R10", 1, 1, 1, 1, 1);
    drive("R4 R6", 1, 0, 0, 0, 0);
    drive("R6", 1, 1, 0, 1, 1);
    drive("R6", 0, 1, 1, 1, 1);

    wr(8'h03);
    drive("R7", 1, 1, 1, 1, 1);
    drive("R7", 1, 0, 0, 1, 0);

    wr(8'h02);
    drive("R8 R4", 1, 1, 0, 1, 1);
    drive("R8", 1, 0, 0, 1, 1);

    wr(8'h00);
    drive("R9", 1, 1, 1, 1, 1);

    size = 2'b00;
    wr(8'h01);
    drive("R5", 1, 1, 1, 1, 1);
    wr(8'h02);
    drive("R5", 1, 1, 0, 1, 1);

    size = 2'b10;
    wr(8'h31);
    drive("R11", 1, 1, 1, 1, 1);
    size = 2'b01;
    drive("R10", 1, 1, 1, 1, 1);
    size = 2'b10;
    wr(8'h01);
    drive("R10", 1, 1, 1, 1, 1);

    wr(8'h09);
    drive("R12", 1, 1, 1, 1, 1);
    wr(8'h11);
    drive("R12", 1, 1, 1, 1, 1);
    wr(8'h21);
    drive("R12", 1, 1, 1, 1, 1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule